// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block sits between a CPU that reads memory sixteen bits at a time and a memory controller that delivers four-word bursts. Each cache line holds one burst. A line is placed by set index into one of two ways. The ways live side by side in an on-chip data array and a tag array, both 18 bits wide. Within each array, the way bit sits on top of the set index to form the line address.

On a read, both candidate lines of the set are looked up together. Their stored tags are compared with the upper address bits, and a valid hit returns the addressed word. A miss evicts the least recently used way of the pair, fetches the whole burst into it, and then answers the request.

The valid flag of a line lives in a spare bit of that line's word-0 data entry. After reset, the block clears all lines in a sweep before it accepts any request. A CPU write does not store data. It only invalidates a matching resident line and is then acknowledged.

Top module: `twoway_read_cache`

## Requirements
- R1: After reset, `req_ready` stays low for at least 128 cycles while every line is cleared. After that, every line is invalid, so the first read of any address misses.
- R2: A read hit returns the 16-bit word of the line chosen by address bits 2:1, with 0 selecting the first burst word. `rsp_valid` rises on the second rising clock edge after the accepting edge, and no memory request is made.
- R3: Address bits 8:3 select one of 64 sets, and bits 25:9 are the tag. Two lines whose addresses share a set but differ in tag can be resident at the same time, and at most one way ever matches.
- R4: On a read miss, `mem_req` is raised with `mem_line_addr` equal to address bits 25:3, and both are held until `mem_ack`. The next four `mem_rvalid` beats are burst words 0 to 3 in that order, and the response carries the beat selected by address bits 2:1.
- R5: A miss fills way 0 if way 0 is invalid, otherwise way 1 if way 1 is invalid, and otherwise the way not most recently used. A hit or a fill makes its way most recently used and the other way not.
- R6: A write whose address is resident invalidates that line, so the next read of it misses. A write to a non-resident address changes nothing. Both kinds are acknowledged with `rsp_valid` at the hit latency and issue no memory request.
- R7: Address bit 0 is ignored. An odd byte address returns the same word as the even address below it.
- R8: Each accepted request produces exactly one `rsp_valid` pulse, one cycle wide. `mem_req` is never high while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request present |
| req_write | input | 1 | 1 = write (invalidate only), 0 = read |
| req_addr | input | 26 | CPU byte address |
| req_ready | output | 1 | Block idle; a request is taken on this edge |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 16 | Read word (zero for write acknowledgements) |
| mem_req | output | 1 | Burst fill request |
| mem_line_addr | output | 23 | Line address of the fill (byte address bits 25:3) |
| mem_ack | input | 1 | Memory controller accepts the fill request |
| mem_rvalid | input | 1 | Burst beat valid |
| mem_rdata | input | 16 | Burst beat data |

## Verification
The bench builds the block with its default parameters: a 26-bit address, 16-bit words, four-word lines and 64 sets. It runs a reference model of tags, valid flags and recency per set, fed mostly from a small pool of sets and tags so that three or more tags fight over the same pair of ways. This pool brings evictions, recency flips, invalidations of resident lines and refills of invalidated ways within reach in a few hundred operations. It also puts pressure on the highest set and an all-ones tag at the edges of the fields.

// File: rtl/rc_pkg.sv
package rc_pkg;
    typedef enum logic [2:0] {
        S_INIT   = 3'd0,
        S_IDLE   = 3'd1,
        S_LOOKUP = 3'd2,
        S_RESP   = 3'd3,
        S_FREQ   = 3'd4,
        S_FDATA  = 3'd5,
        S_FTAG   = 3'd6,
        S_FMRU   = 3'd7
    } rc_state_e;
endpackage

// File: rtl/rc_sram.sv
module rc_sram #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    ra0,
    input  logic [AW-1:0]    ra1,
    output logic [WIDTH-1:0] rq0,
    output logic [WIDTH-1:0] rq1
);
    logic [WIDTH-1:0] mem [DEPTH];

    // synchronous read on both ports, old data on read-during-write
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rq0 <= mem[ra0];
        rq1 <= mem[ra1];
    end
endmodule

// File: rtl/rc_way_match.sv
module rc_way_match #(
    parameter int TAG_W = 17
) (
    input  logic [TAG_W:0]   tword [2],
    input  logic [1:0]       valid,
    input  logic [TAG_W-1:0] ref_tag,
    output logic [1:0]       hit,
    output logic             hit_way,
    output logic             victim
);
    for (genvar g = 0; g < 2; g++) begin : g_way
        assign hit[g] = valid[g] && (tword[g][TAG_W-1:0] == ref_tag);
    end

    assign hit_way = hit[1];

    // invalid way 0 first, then invalid way 1, else the way not recently used
    always_comb begin
        if (!valid[0])      victim = 1'b0;
        else if (!valid[1]) victim = 1'b1;
        else                victim = tword[0][TAG_W];
    end

    logic unused_mru1;
    assign unused_mru1 = tword[1][TAG_W];
endmodule

// File: rtl/twoway_read_cache.sv
module twoway_read_cache #(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 16,
    parameter int SET_W  = 6,
    parameter int WORD_W = 2,
    localparam int TAG_W   = ADDR_W - SET_W - WORD_W - 1,
    localparam int LINE_W  = SET_W + 1,
    localparam int DAW     = LINE_W + WORD_W,
    localparam int RAM_W   = DATA_W + 2,
    localparam int LADDR_W = ADDR_W - WORD_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               mem_req,
    output logic [LADDR_W-1:0] mem_line_addr,
    input  logic               mem_ack,
    input  logic               mem_rvalid,
    input  logic [DATA_W-1:0]  mem_rdata
);
    import rc_pkg::*;

    typedef struct packed {
        rc_state_e          state;
        logic [LINE_W-1:0]  sweep;
        logic [ADDR_W-1:0]  addr;
        logic               write;
        logic               victim;
        logic [WORD_W-1:0]  beat;
        logic [DATA_W-1:0]  word;
        logic [TAG_W:0]     oth_tag;
        logic               rsp_valid;
        logic [DATA_W-1:0]  rsp_data;
    } st_t;

    st_t r_q, r_d;

    // RAM wiring
    logic             tag_we, dat_we;
    logic [LINE_W-1:0] tag_wa, tra0, tra1;
    logic [TAG_W:0]    tag_wd, tq0, tq1;
    logic [DAW-1:0]    dat_wa, dra0, dra1;
    logic [RAM_W-1:0]  dat_wd, dq0, dq1;

    rc_sram #(.WIDTH(TAG_W + 1), .DEPTH(1 << LINE_W)) u_tag_ram (
        .clk(clk), .we(tag_we), .waddr(tag_wa), .wdata(tag_wd),
        .ra0(tra0), .ra1(tra1), .rq0(tq0), .rq1(tq1)
    );

    rc_sram #(.WIDTH(RAM_W), .DEPTH(1 << DAW)) u_data_ram (
        .clk(clk), .we(dat_we), .waddr(dat_wa), .wdata(dat_wd),
        .ra0(dra0), .ra1(dra1), .rq0(dq0), .rq1(dq1)
    );

    // address fields
    logic [SET_W-1:0]  req_set, cur_set;
    logic [WORD_W-1:0] cur_word;
    logic [TAG_W-1:0]  cur_tag;
    assign req_set  = req_addr[WORD_W+SET_W:WORD_W+1];
    assign cur_set  = r_q.addr[WORD_W+SET_W:WORD_W+1];
    assign cur_word = r_q.addr[WORD_W:1];
    assign cur_tag  = r_q.addr[ADDR_W-1:WORD_W+SET_W+1];

    // way compare
    logic [TAG_W:0] tword [2];
    logic [1:0]     way_valid, way_hit;
    logic           hit_way, victim, any_hit;
    assign tword[0]     = tq0;
    assign tword[1]     = tq1;
    assign way_valid[0] = dq0[DATA_W];
    assign way_valid[1] = dq1[DATA_W];
    assign any_hit      = |way_hit;

    rc_way_match #(.TAG_W(TAG_W)) u_match (
        .tword(tword), .valid(way_valid), .ref_tag(cur_tag),
        .hit(way_hit), .hit_way(hit_way), .victim(victim)
    );

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        tag_we = 1'b0; tag_wa = '0; tag_wd = '0;
        dat_we = 1'b0; dat_wa = '0; dat_wd = '0;
        tra0 = {1'b0, req_set};
        tra1 = {1'b1, req_set};
        dra0 = {1'b0, req_set, {WORD_W{1'b0}}};
        dra1 = {1'b1, req_set, {WORD_W{1'b0}}};
        unique case (r_q.state)
            S_INIT: begin
                tag_we = 1'b1;
                tag_wa = r_q.sweep;
                dat_we = 1'b1;
                dat_wa = {r_q.sweep, {WORD_W{1'b0}}};
                r_d.sweep = r_q.sweep + 1'b1;
                if (r_q.sweep == {LINE_W{1'b1}}) r_d.state = S_IDLE;
            end
            S_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.write = req_write;
                    r_d.state = S_LOOKUP;
                end
            end
            S_LOOKUP: begin
                dra0 = {hit_way, cur_set, cur_word};
                if (any_hit) begin
                    r_d.victim  = hit_way;
                    r_d.oth_tag = hit_way ? tq0 : tq1;
                    if (r_q.write) begin
                        dat_we = 1'b1;
                        dat_wa = {hit_way, cur_set, {WORD_W{1'b0}}};
                        dat_wd = {2'b00, hit_way ? dq1[DATA_W-1:0] : dq0[DATA_W-1:0]};
                    end else begin
                        tag_we = 1'b1;
                        tag_wa = {hit_way, cur_set};
                        tag_wd = {1'b1, cur_tag};
                    end
                    r_d.state = S_RESP;
                end else if (r_q.write) begin
                    r_d.state = S_RESP;
                end else begin
                    r_d.victim  = victim;
                    r_d.oth_tag = victim ? tq0 : tq1;
                    r_d.beat    = '0;
                    r_d.state   = S_FREQ;
                end
            end
            S_RESP: begin
                r_d.rsp_valid = 1'b1;
                r_d.rsp_data  = r_q.write ? '0 : dq0[DATA_W-1:0];
                if (!r_q.write) begin
                    tag_we = 1'b1;
                    tag_wa = {~r_q.victim, cur_set};
                    tag_wd = {1'b0, r_q.oth_tag[TAG_W-1:0]};
                end
                r_d.state = S_IDLE;
            end
            S_FREQ: begin
                if (mem_ack) r_d.state = S_FDATA;
            end
            S_FDATA: begin
                if (mem_rvalid) begin
                    dat_we = 1'b1;
                    dat_wa = {r_q.victim, cur_set, r_q.beat};
                    dat_wd = {1'b0, (r_q.beat == '0), mem_rdata};
                    if (r_q.beat == cur_word) r_d.word = mem_rdata;
                    r_d.beat = r_q.beat + 1'b1;
                    if (r_q.beat == {WORD_W{1'b1}}) r_d.state = S_FTAG;
                end
            end
            S_FTAG: begin
                tag_we = 1'b1;
                tag_wa = {r_q.victim, cur_set};
                tag_wd = {1'b1, cur_tag};
                r_d.state = S_FMRU;
            end
            S_FMRU: begin
                tag_we = 1'b1;
                tag_wa = {~r_q.victim, cur_set};
                tag_wd = {1'b0, r_q.oth_tag[TAG_W-1:0]};
                r_d.rsp_valid = 1'b1;
                r_d.rsp_data  = r_q.word;
                r_d.state     = S_IDLE;
            end
            default: r_d.state = S_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req_ready     = (r_q.state == S_IDLE);
    assign rsp_valid     = r_q.rsp_valid;
    assign rsp_data      = r_q.rsp_data;
    assign mem_req       = (r_q.state == S_FREQ);
    assign mem_line_addr = r_q.addr[ADDR_W-1:WORD_W+1];

    logic unused_bits;
    assign unused_bits = ^{req_addr[0], dq0[RAM_W-1], dq1[RAM_W-1], r_q.oth_tag[TAG_W]};

    // R3: a tag is resident in at most one way of a set
    p_single_way_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_LOOKUP) |-> !(way_hit[0] && way_hit[1]));

    // R4: fill request and its line address hold until accepted
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_line_addr)));

    // R4: the fourth beat closes the data phase
    p_last_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_FDATA && mem_rvalid && r_q.beat == {WORD_W{1'b1}}) |=> (r_q.state == S_FTAG));

    // R8: responses are single-cycle pulses
    p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8: no fill request while idle
    p_idle_no_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);
endmodule

// File: tb/twoway_read_cache_bench.sv
module twoway_read_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [25:0] req_addr = '0;
    logic        req_ready, rsp_valid, mem_req;
    logic [15:0] rsp_data;
    logic [22:0] mem_line_addr;
    logic        mem_ack = 1'b0, mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;

    always #10 clk = ~clk;

    twoway_read_cache u_twoway_read_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .mem_req(mem_req), .mem_line_addr(mem_line_addr),
        .mem_ack(mem_ack), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int tests = 0, fails = 0, fills = 0;
    logic [22:0] last_line = '0;
    bit done = 0;

    // reference model
    bit [16:0] mtag [2][64];
    bit        mval [2][64];
    bit        mmru [2][64];

    function automatic logic [15:0] mem_word(input logic [22:0] line, input logic [1:0] w);
        logic [31:0] h;
        h = ({9'd0, line} * 32'h9E37) ^ ({30'd0, w} * 32'h3C1) ^ ({9'd0, line} >> 7);
        return h[15:0] ^ h[31:16];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory controller responder
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                logic [22:0] ln;
                ln = mem_line_addr;
                last_line = ln;
                fills++;
                repeat ($urandom_range(0, 3)) @(negedge clk);
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
                for (int b = 0; b < 4; b++) begin
                    repeat ($urandom_range(0, 2)) @(negedge clk);
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem_word(ln, 2'(b));
                    @(negedge clk);
                    mem_rvalid = 1'b0;
                end
            end
        end
    end

    task automatic access(input bit wr, input logic [25:0] a, input string req);
        int s, way, cyc, f0;
        bit hit, v;
        logic [16:0] t;
        logic [15:0] exp;
        s = int'(a[8:3]); t = a[25:9]; hit = 0; way = 0;
        for (int w = 0; w < 2; w++)
            if (mval[w][s] && mtag[w][s] == t) begin hit = 1; way = w; end
        exp = wr ? 16'h0 : mem_word(a[25:3], a[2:1]);
        if (wr) begin
            if (hit) mval[way][s] = 0;
        end else begin
            if (!hit) begin
                if (!mval[0][s]) v = 0; else if (!mval[1][s]) v = 1; else v = mmru[0][s];
                way = int'(v);
                mtag[way][s] = t; mval[way][s] = 1;
            end
            mmru[way][s] = 1; mmru[1-way][s] = 0;
        end
        while (!req_ready) @(negedge clk);
        f0 = fills;
        req_valid = 1'b1; req_write = wr; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!rsp_valid && cyc < 200) begin @(negedge clk); cyc++; end
        check(rsp_valid, {req, " R8 response seen"}, 32'(rsp_valid), 1);
        check(rsp_data == exp, {req, " R2/R4 data"}, 32'(rsp_data), 32'(exp));
        if (wr || hit) begin
            check(cyc == 3, {req, " R2/R6 latency"}, 32'(cyc), 3);
            check(fills == f0, {req, " R6 no fill"}, 32'(fills - f0), 0);
        end else begin
            check(fills == f0 + 1, {req, " R5 fill expected"}, 32'(fills - f0), 1);
            check(last_line == a[25:3], {req, " R4 line address"}, 32'(last_line), 32'(a[25:3]));
        end
        @(negedge clk);
        check(!rsp_valid, {req, " R8 single pulse"}, 32'(rsp_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(!rsp_valid && !mem_req && !req_ready, "R1 reset outputs", {29'd0, rsp_valid, mem_req, req_ready}, 0);
        rst_n = 1'b1;
        n = 0;
        while (!req_ready && n < 1000) begin @(negedge clk); n++; end
        check(n >= 128, "R1 clear sweep length", 32'(n), 128);

        // R1: first reads miss; R2: all words of the line then hit
        access(0, 26'h0000040, "R1 cold");
        for (int w = 0; w < 4; w++) access(0, 26'h0000040 | 26'(w << 1), "R2 word select");
        access(0, 26'h0000043, "R7 odd byte");
        // R3: two tags in set 5 resident together
        access(0, {17'h00001, 6'd5, 3'd2}, "R3 A");
        access(0, {17'h00002, 6'd5, 3'd4}, "R3 B");
        access(0, {17'h00001, 6'd5, 3'd0}, "R3 A again");
        access(0, {17'h00002, 6'd5, 3'd6}, "R3 B again");
        // R5: A made recent, C evicts B
        access(0, {17'h00001, 6'd5, 3'd0}, "R5 touch A");
        access(0, {17'h00003, 6'd5, 3'd0}, "R5 C");
        access(0, {17'h00001, 6'd5, 3'd0}, "R5 A kept");
        access(0, {17'h00002, 6'd5, 3'd0}, "R5 B refetch");
        // R6: invalidate and a write to a non-resident line
        access(1, {17'h00001, 6'd5, 3'd0}, "R6 inv A");
        access(1, {17'h1FFFF, 6'd63, 3'd0}, "R6 miss write");
        access(0, {17'h00002, 6'd5, 3'd0}, "R6 B survives");
        access(0, {17'h00001, 6'd5, 3'd0}, "R6 A refetch");
        access(0, {17'h1FFFF, 6'd63, 3'd6}, "R3 top set tag");

        for (int i = 0; i < 400; i++) begin
            logic [16:0] t;
            logic [5:0]  s;
            int k;
            k = $urandom_range(0, 4);
            t = (k == 4) ? 17'h1FFFF : 17'(k);
            k = $urandom_range(0, 4);
            s = (k == 4) ? 6'd63 : 6'(k);
            access($urandom_range(0, 99) < 15, {t, s, 3'($urandom_range(0, 7))}, "R5 random");
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule